// File: doc/BRIEF.md
# SPI Event Interrupt Collector

This block sits beside a serial-peripheral shift engine and turns its event pulses into latched status bits. There are seven sources: mode fault, slave-mode fault, transmit FIFO empty, transmit underrun, receive FIFO full, receive overrun and transmit FIFO half empty. A rising edge on a source sets its pending bit. The bit stays set until software writes a one to it. Writing back the value just read from the status register is enough to acknowledge everything that was seen.

A per-source mask and a single master-enable bit decide whether the pending bits drive the one interrupt line. The interrupt line is registered.

The same register port also decodes a keyed soft-reset register. Writing the key value returns the core to its power-on state. The block then raises a one-cycle request that the FIFOs and control registers use to reset themselves. Any other value written to that register does nothing.

Top module: `spi_irq_hub`

## Requirements
- R1: After rst_ni is released, irq_o and core_rst_o are 0, and reading the status (0x20), mask (0x28) and master-enable (0x1C) registers returns 0.
- R2: A 0-to-1 transition of evt_i[k] sets status bit k at that clock edge. Holding the input high does not set the bit again once it has been cleared.
- R3: A set status bit stays set until a write to offset 0x20 with a 1 in that bit position. Bits written as 0 are left unchanged.
- R4: If a rising edge and a write-one-clear hit the same bit in the same cycle, the bit stays set.
- R5: irq_o equals (master enable) AND OR over k of (status[k] AND mask[k]), sampled one clock later. A pending bit with its mask bit at 0 does not raise irq_o.
- R6: At offset 0x1C only bit 31 is stored, as the master enable. A read returns that bit in position 31 and zeros in bits 30..0.
- R7: Offset 0x28 stores a 7-bit mask in bits 6..0 and reads it back.
- R8: Writing 32'h0000000A to offset 0x40 drives core_rst_o high for the following cycle only. The same edge clears the status, mask and master enable, and irq_o goes low.
- R9: Writing any other value to offset 0x40 has no effect on any output or register. Reading offset 0x40 returns 0.
- R10: Status bit positions follow evt_i positions: bit 0 mode fault, 1 slave-mode fault, 2 TX empty, 3 TX underrun, 4 RX full, 5 RX overrun, 6 TX half empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Register byte offset for reads and writes |
| reg_we_i | input | 1 | Write strobe, one write per cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| evt_i | input | 7 | Event inputs from the shift engine |
| irq_o | output | 1 | Registered interrupt request |
| core_rst_o | output | 1 | One-cycle reset request to FIFOs and control |

## Verification
The assertions assume that evt_i is synchronous to clk_i and that at most one register write is presented per cycle. They also assume reads are side-effect free, so the address may be moved freely while reg_we_i is low. The stimulus changes every input only on the falling edge. It raises events as single-cycle or multi-cycle levels, with at least one low cycle between them, so that every intended rising edge is visible. Same-cycle event and clear, masked-but-pending sources, and wrong-key writes to the reset register are each driven on purpose.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_SRC   = 7;
  localparam int unsigned GIE_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_GIE  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_RST  = 8'h40;
  localparam logic [DATA_W-1:0] RST_KEY  = 32'h0000_000A;
endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int unsigned N_SRC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             soft_clr_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] evt_q, status_q, rise;

  assign rise = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= '0;
      status_q <= '0;
    end else begin
      evt_q <= evt_i;
      if (soft_clr_i) status_q <= '0;
      else            status_q <= (status_q & ~clr_i) | rise; // set beats clear
    end
  end

  assign status_o = status_q;

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_clr_i |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i))); // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_clr_i |=> ((status_q & $past(rise)) == $past(rise))); // R4
endmodule

// File: rtl/irq_soft_rst.sv
module irq_soft_rst
  import spi_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              clr_o,
  output logic              rst_req_o
);
  logic rst_q;

  assign clr_o = we_i && (addr_i == OFS_RST) && (wdata_i == RST_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= clr_o;
  end

  assign rst_req_o = rst_q;

  AST_KEY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_RST && wdata_i != RST_KEY) |=> !rst_req_o); // R9
endmodule

// File: rtl/spi_irq_hub.sv
module spi_irq_hub
  import spi_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_SRC-1:0]  evt_i,
  output logic              irq_o,
  output logic              core_rst_o
);
  logic [N_SRC-1:0] status, mask_q, stat_clr;
  logic             gie_q, irq_q, soft_clr;

  assign stat_clr = (reg_we_i && reg_addr_i == OFS_STAT) ? reg_wdata_i[N_SRC-1:0] : '0;

  irq_soft_rst u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .clr_o     (soft_clr),
    .rst_req_o (core_rst_o)
  );

  irq_evt_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .clr_i      (stat_clr),
    .soft_clr_i (soft_clr),
    .status_o   (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (soft_clr) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == OFS_MASK) mask_q <= reg_wdata_i[N_SRC-1:0];
      if (reg_we_i && reg_addr_i == OFS_GIE)  gie_q  <= reg_wdata_i[GIE_BIT];
      irq_q <= gie_q & |(status & mask_q);
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_GIE:  reg_rdata_o[GIE_BIT]   = gie_q;
      OFS_STAT: reg_rdata_o[N_SRC-1:0] = status;
      OFS_MASK: reg_rdata_o[N_SRC-1:0] = mask_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gie_q)); // R5
  AST_SOFT_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> (status == '0 && mask_q == '0 && !gie_q && !irq_o)); // R8
  AST_GIE_RD_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFS_GIE) |-> (reg_rdata_o[GIE_BIT-1:0] == '0)); // R6
  AST_RST_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFS_RST) |-> (reg_rdata_o == '0)); // R9
endmodule

// File: tb/tb_spi_irq_hub.sv
module tb_spi_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  evt = '0;
  logic        irq, crst;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  spi_irq_hub dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
    .irq_o(irq), .core_rst_o(crst)
  );

  typedef struct packed {
    logic [6:0]  evt;
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  // checks are taken before the edge that applies the row
  localparam vec_t VEC [21] = '{
    '{7'h00, 1'b0, 8'h20, 32'h0,         32'h0,         1'b0, 4'd1},  // R1
    '{7'h04, 1'b0, 8'h20, 32'h0,         32'h0,         1'b0, 4'd2},  // R2 edge
    '{7'h04, 1'b0, 8'h20, 32'h0,         32'h04,        1'b0, 4'd2},
    '{7'h00, 1'b1, 8'h28, 32'h04,        32'h0,         1'b0, 4'd7},  // R7
    '{7'h00, 1'b0, 8'h28, 32'h0,         32'h04,        1'b0, 4'd7},
    '{7'h00, 1'b1, 8'h1C, 32'h8000_0000, 32'h0,         1'b0, 4'd6},
    '{7'h00, 1'b0, 8'h1C, 32'h0,         32'h8000_0000, 1'b0, 4'd5},  // R5 latency
    '{7'h00, 1'b0, 8'h20, 32'h0,         32'h04,        1'b1, 4'd5},
    '{7'h00, 1'b1, 8'h20, 32'h0,         32'h04,        1'b1, 4'd3},  // R3 zero write
    '{7'h00, 1'b0, 8'h20, 32'h0,         32'h04,        1'b1, 4'd3},
    '{7'h00, 1'b1, 8'h20, 32'h04,        32'h04,        1'b1, 4'd3},
    '{7'h00, 1'b0, 8'h20, 32'h0,         32'h0,         1'b1, 4'd3},
    '{7'h00, 1'b0, 8'h20, 32'h0,         32'h0,         1'b0, 4'd5},
    '{7'h01, 1'b0, 8'h20, 32'h0,         32'h0,         1'b0, 4'd5},  // R5 masked
    '{7'h01, 1'b0, 8'h20, 32'h0,         32'h01,        1'b0, 4'd5},
    '{7'h00, 1'b0, 8'h20, 32'h0,         32'h01,        1'b0, 4'd5},
    '{7'h01, 1'b1, 8'h20, 32'h01,        32'h01,        1'b0, 4'd4},  // R4
    '{7'h00, 1'b0, 8'h20, 32'h0,         32'h01,        1'b0, 4'd4},
    '{7'h00, 1'b1, 8'h1C, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 4'd6},  // R6
    '{7'h00, 1'b0, 8'h1C, 32'h0,         32'h0,         1'b0, 4'd6},
    '{7'h00, 1'b0, 8'h40, 32'h0,         32'h0,         1'b0, 4'd9}   // R9 read
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [6:0] e, logic w, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    evt = e; we = w; addr = a; wdata = d;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 core_rst", {31'b0, crst}, 32'h0);
    step(7'h0, 1'b0, 8'h28, 32'h0); chk("R1 mask", rdata, 32'h0);
    step(7'h0, 1'b0, 8'h1C, 32'h0); chk("R1 gie", rdata, 32'h0);

    for (int i = 0; i < 21; i++) begin
      step(VEC[i].evt, VEC[i].we, VEC[i].addr, VEC[i].wdata);
      chk($sformatf("R%0d row%0d rdata", VEC[i].req, i), rdata, VEC[i].exp_rd);
      chk($sformatf("R%0d row%0d irq", VEC[i].req, i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
    end

    // R5: enable all, raise RX overrun; status now 0x21
    step(7'h00, 1'b1, 8'h28, 32'h7F);
    step(7'h00, 1'b1, 8'h1C, 32'h8000_0000);
    step(7'h20, 1'b0, 8'h20, 32'h0);
    step(7'h00, 1'b0, 8'h20, 32'h0);
    step(7'h00, 1'b0, 8'h20, 32'h0);
    chk("R5 irq enabled", {31'b0, irq}, 32'h1);
    chk("R5 status", rdata, 32'h21);

    // R9: wrong key ignored
    step(7'h00, 1'b1, 8'h40, 32'h0B);
    step(7'h00, 1'b0, 8'h20, 32'h0);
    chk("R9 core_rst", {31'b0, crst}, 32'h0);
    chk("R9 status kept", rdata, 32'h21);
    chk("R9 irq kept", {31'b0, irq}, 32'h1);

    // R8: key resets
    step(7'h00, 1'b1, 8'h40, 32'h0A);
    step(7'h00, 1'b0, 8'h20, 32'h0);
    chk("R8 core_rst pulse", {31'b0, crst}, 32'h1);
    chk("R8 status clr", rdata, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    step(7'h00, 1'b0, 8'h28, 32'h0);
    chk("R8 core_rst one cycle", {31'b0, crst}, 32'h0);
    chk("R8 mask clr", rdata, 32'h0);
    step(7'h00, 1'b0, 8'h1C, 32'h0);
    chk("R8 gie clr", rdata, 32'h0);

    // R10: position map
    for (int i = 0; i < 7; i++) begin
      step(7'(1 << i), 1'b0, 8'h20, 32'h0);
      step(7'h00, 1'b0, 8'h20, 32'h0);
      chk($sformatf("R10 src%0d", i), rdata, 32'(1 << i));
      step(7'h00, 1'b1, 8'h20, 32'(1 << i));
    end

    // R2: held level does not re-set after clear
    step(7'h08, 1'b0, 8'h20, 32'h0);
    step(7'h08, 1'b1, 8'h20, 32'h08);
    step(7'h08, 1'b0, 8'h20, 32'h0);
    step(7'h08, 1'b0, 8'h20, 32'h0);
    chk("R2 no re-set on level", rdata, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule